// File: doc/BRIEF.md
# Flash Command Queue with High-Voltage Sequencing

This block sits between a processor's register interface and a flash array. Software writes program and erase commands into a two-deep pending queue. A sequencer takes each command from the queue and ramps up the high programming voltage. It then holds the array strobe for a fixed busy count and ramps the voltage down again. Because the queue is two deep, software can hand over the next command while the current one is still running.

The main saving comes from back-to-back programming. A program command is followed straight away by a queued program whose address lies in the same 64-byte row. In that case the voltage is left on and the second program starts in the very next cycle, with no ramp-down and ramp-up between them. Any other pairing drops the voltage first: a type change, a different row, two erases, or an empty queue.

Two status flags report progress. One marks a finished operation and the other an empty queue, and each has its own interrupt enable. A sticky error flag records commands that were refused. The array, charge pump and analog timing are modelled by parameterised cycle counts.

Top module: `fcq_top`

## Requirements
- R1: After reset, hv_en, arr_pgm, arr_ers, cc_flag, acc_err, cc_irq and be_irq are 0 and be_flag is 1.
- R2: cmd_op 2'b01 is a program (address and data) and 2'b10 an erase (address only). Commands execute strictly in write order, and arr_addr/arr_data show the executing command while its strobe is high. arr_pgm and arr_ers are never high together.
- R3: A command reaching an idle sequencer raises hv_en on the cycle after it is taken from the queue. After RAMP_UP cycles the strobe is held for PGM_CYC (program) or ERS_CYC (erase) cycles. hv_en is high for the whole strobe.
- R4: A program may be followed by a queued program whose address bits above bit 5 match. In that case hv_en stays high and the second strobe begins on the cycle right after the first ends.
- R5: Every other successor drops hv_en for RAMP_DN cycles, then idles one cycle, then ramps again. This covers a type change, a different row, erase after erase, and no queued command.
- R6: cc_flag is set at the end of every array operation and held until a cc_clr pulse. A completion in the same cycle as cc_clr leaves it set.
- R7: be_flag is 1 exactly when no command is waiting in the queue. The executing command does not count.
- R8: A write while two commands wait, or with cmd_op 2'b00 or 2'b11, is not stored. It sets acc_err, which stays 1 until an err_clr pulse.
- R9: cc_irq is high while cc_ie and cc_flag are both 1, and be_irq is high while be_ie and be_flag are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | One-cycle command write strobe |
| cmd_op | input | 2 | Opcode: 01 program, 10 erase |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | DATA_W | Program data word |
| cc_clr | input | 1 | Write-one clear of cc_flag |
| err_clr | input | 1 | Clear of acc_err |
| cc_ie | input | 1 | Completion interrupt enable |
| be_ie | input | 1 | Queue-empty interrupt enable |
| hv_en | output | 1 | High-voltage request to the pump |
| arr_pgm | output | 1 | Program strobe to the array |
| arr_ers | output | 1 | Erase strobe to the array |
| arr_addr | output | ADDR_W | Address of the running operation |
| arr_data | output | DATA_W | Data of the running operation |
| cc_flag | output | 1 | Command-complete flag |
| be_flag | output | 1 | Queue-empty flag |
| acc_err | output | 1 | Sticky rejected-write flag |
| cc_irq | output | 1 | Completion interrupt |
| be_irq | output | 1 | Queue-empty interrupt |

## Verification
The bench times command pairs on both sides of the row boundary at address 0x40. A design that compared too few or too many address bits would merge across rows, or split programs within a row. That shows up as the wrong count of voltage ramps and the wrong finishing cycle. Erase-after-erase and type-changing pairs check that only program pairs ever share one ramp. A fourth write into a full queue and illegal opcodes must leave no trace on the array and raise the error flag. A queue that overwrote an entry would program the refused address. The empty flag is sampled on the cycle a command leaves the queue, which catches a design that counts the executing command as pending.

// File: rtl/fcq_pkg.sv
// Package: shared opcode and sequencer-state types for the flash command queue.
// Assumes opcodes are two bits wide and only two of the four codes are legal.
package fcq_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PGM  = 2'b01,
        OP_ERS  = 2'b10,
        OP_BAD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_RAMP  = 2'b01,
        S_EXEC  = 2'b10,
        S_DRAIN = 2'b11
    } seq_e;

    // Legal opcodes are program and erase only.
    function automatic logic op_legal(input logic [1:0] op);
        return (op == OP_PGM) || (op == OP_ERS);
    endfunction

endpackage

// File: rtl/fcq_fifo.sv
// Module: fcq_fifo
// Small in-order queue of pending commands (opcode, address, data).
// Assumes the caller never pushes while full; a push and pop may share a cycle.
module fcq_fifo #(
    parameter int DEPTH  = 2,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [1:0]        push_op,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              empty,
    output logic              full,
    output logic [1:0]        head_op,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [1:0]        op_q   [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    assign empty     = (count == '0);
    assign full      = (count == CNT_W'(DEPTH));
    assign head_op   = op_q[rd_ptr];
    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];

    // Storage slots: each entry loads only when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                op_q[g]   <= 2'b00;
                addr_q[g] <= '0;
                data_q[g] <= '0;
            end else if (push && (wr_ptr == PTR_W'(g))) begin
                op_q[g]   <= push_op;
                addr_q[g] <= push_addr;
                data_q[g] <= push_data;
            end
        end
    end

    // Pointer and occupancy bookkeeping with explicit wrap at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/fcq_hv_seq.sv
// Module: fcq_hv_seq
// Execution sequencer: ramps high voltage, strobes the array for a fixed busy
// count, and chains a queued same-row program without dropping the voltage.
// Assumes every cycle-count parameter is at least 1.
module fcq_hv_seq
    import fcq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int ROW_LSB  = 6,
    parameter int RAMP_UP  = 4,
    parameter int RAMP_DN  = 3,
    parameter int PGM_CYC  = 8,
    parameter int ERS_CYC  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic [1:0]        head_op,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    output logic              pop,
    output logic              op_done,
    output logic              hv_en,
    output logic              arr_pgm,
    output logic              arr_ers,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data
);
    localparam int MAX_A = (RAMP_UP > RAMP_DN) ? RAMP_UP : RAMP_DN;
    localparam int MAX_B = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam int ROW_W = ADDR_W - ROW_LSB;

    seq_e              state;
    logic [CNT_W-1:0]  cnt;
    op_e               cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_data;
    logic              last;
    logic              same_row;
    logic              chain;

    // Chain decision: both program, same row, successor already queued.
    always_comb begin
        last     = (cnt == '0);
        same_row = (head_addr[ADDR_W-1 -: ROW_W] == cur_addr[ADDR_W-1 -: ROW_W]);
        chain    = head_valid && (cur_op == OP_PGM) && (op_e'(head_op) == OP_PGM) && same_row;
        pop      = ((state == S_IDLE) && head_valid) ||
                   ((state == S_EXEC) && last && chain);
    end

    // Main sequencer: idle -> ramp -> execute (possibly chained) -> drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            cur_op   <= OP_NONE;
            cur_addr <= '0;
            cur_data <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (head_valid) begin
                        cur_op   <= op_e'(head_op);
                        cur_addr <= head_addr;
                        cur_data <= head_data;
                        cnt      <= CNT_W'(RAMP_UP - 1);
                        state    <= S_RAMP;
                    end
                end
                S_RAMP: begin
                    if (last) begin
                        cnt   <= (cur_op == OP_ERS) ? CNT_W'(ERS_CYC - 1) : CNT_W'(PGM_CYC - 1);
                        state <= S_EXEC;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_EXEC: begin
                    if (last && chain) begin
                        cur_op   <= OP_PGM;
                        cur_addr <= head_addr;
                        cur_data <= head_data;
                        cnt      <= CNT_W'(PGM_CYC - 1);
                    end else if (last) begin
                        cnt   <= CNT_W'(RAMP_DN - 1);
                        state <= S_DRAIN;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (last)
                        state <= S_IDLE;
                    else
                        cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    // Array-side outputs decoded from sequencer state.
    always_comb begin
        hv_en    = (state == S_RAMP) || (state == S_EXEC);
        arr_pgm  = (state == S_EXEC) && (cur_op == OP_PGM);
        arr_ers  = (state == S_EXEC) && (cur_op == OP_ERS);
        op_done  = (state == S_EXEC) && last;
        arr_addr = cur_addr;
        arr_data = cur_data;
    end

endmodule

// File: rtl/fcq_status.sv
// Module: fcq_status
// Status flags and interrupt requests for the command queue.
// Assumes op_done and wr_reject are single-cycle pulses from the datapath.
module fcq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic op_done,
    input  logic wr_reject,
    input  logic queue_empty,
    input  logic cc_clr,
    input  logic err_clr,
    input  logic cc_ie,
    input  logic be_ie,
    output logic cc_flag,
    output logic be_flag,
    output logic acc_err,
    output logic cc_irq,
    output logic be_irq
);
    // Completion flag: set by a finished operation, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cc_flag <= 1'b0;
        else if (op_done)
            cc_flag <= 1'b1;
        else if (cc_clr)
            cc_flag <= 1'b0;
    end

    // Sticky error flag: set by a refused write, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_err <= 1'b0;
        else if (wr_reject)
            acc_err <= 1'b1;
        else if (err_clr)
            acc_err <= 1'b0;
    end

    // Empty flag follows queue occupancy; interrupts gate flags with enables.
    always_comb begin
        be_flag = queue_empty;
        cc_irq  = cc_ie && cc_flag;
        be_irq  = be_ie && be_flag;
    end

endmodule

// File: rtl/fcq_top.sv
// Module: fcq_top
// Flash command queue: two-deep pending queue, high-voltage sequencer and
// status/interrupt logic. Assumes a single write strobe per command.
module fcq_top
    import fcq_pkg::*;
#(
    parameter int DEPTH   = 2,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int ROW_LSB = 6,
    parameter int RAMP_UP = 4,
    parameter int RAMP_DN = 3,
    parameter int PGM_CYC = 8,
    parameter int ERS_CYC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cc_clr,
    input  logic              err_clr,
    input  logic              cc_ie,
    input  logic              be_ie,
    output logic              hv_en,
    output logic              arr_pgm,
    output logic              arr_ers,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    output logic              cc_flag,
    output logic              be_flag,
    output logic              acc_err,
    output logic              cc_irq,
    output logic              be_irq
);
    logic              q_empty, q_full, q_pop, q_push;
    logic [1:0]        head_op;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic              wr_reject, op_done;

    // Write acceptance: legal opcode and room in the queue.
    always_comb begin
        q_push    = cmd_wr && !q_full && op_legal(cmd_op);
        wr_reject = cmd_wr && !q_push;
    end

    fcq_fifo #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_op   (cmd_op),
        .push_addr (cmd_addr),
        .push_data (cmd_data),
        .pop       (q_pop),
        .empty     (q_empty),
        .full      (q_full),
        .head_op   (head_op),
        .head_addr (head_addr),
        .head_data (head_data)
    );

    fcq_hv_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ROW_LSB (ROW_LSB),
        .RAMP_UP (RAMP_UP),
        .RAMP_DN (RAMP_DN),
        .PGM_CYC (PGM_CYC),
        .ERS_CYC (ERS_CYC)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (!q_empty),
        .head_op    (head_op),
        .head_addr  (head_addr),
        .head_data  (head_data),
        .pop        (q_pop),
        .op_done    (op_done),
        .hv_en      (hv_en),
        .arr_pgm    (arr_pgm),
        .arr_ers    (arr_ers),
        .arr_addr   (arr_addr),
        .arr_data   (arr_data)
    );

    fcq_status i_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_done     (op_done),
        .wr_reject   (wr_reject),
        .queue_empty (q_empty),
        .cc_clr      (cc_clr),
        .err_clr     (err_clr),
        .cc_ie       (cc_ie),
        .be_ie       (be_ie),
        .cc_flag     (cc_flag),
        .be_flag     (be_flag),
        .acc_err     (acc_err),
        .cc_irq      (cc_irq),
        .be_irq      (be_irq)
    );

endmodule

// File: rtl/fcq_checker.sv
// Module: fcq_checker
// Temporal checks on the queue's ports, bound into every fcq_top instance.
// Assumes reset is held for at least one clock edge at start-up.
module fcq_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_wr,
    input logic hv_en,
    input logic arr_pgm,
    input logic arr_ers,
    input logic cc_flag,
    input logic be_flag,
    input logic acc_err
);
    // R2: at most one kind of array strobe at a time.
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_pgm && arr_ers));

    // R3: the voltage is up whenever the array is strobed.
    p_hv_covers_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_pgm || arr_ers) |-> hv_en);

    // R5: the voltage only drops right after an array operation.
    p_hv_drop_after_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hv_en) |-> $past(arr_pgm || arr_ers));

    // R6: completion flag rises only after a strobe cycle.
    p_cc_after_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_flag) |-> $past(arr_pgm || arr_ers));

    // R7: the queue becomes non-empty only through a write.
    p_be_fall_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(be_flag) |-> $past(cmd_wr));

    // R8: the error flag rises only after a write attempt.
    p_err_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_err) |-> $past(cmd_wr));

endmodule

bind fcq_top fcq_checker i_fcq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (cmd_wr),
    .hv_en   (hv_en),
    .arr_pgm (arr_pgm),
    .arr_ers (arr_ers),
    .cc_flag (cc_flag),
    .be_flag (be_flag),
    .acc_err (acc_err)
);

// File: tb/test_fcq_top.sv
module test_fcq_top;

    localparam int LOGN = 90;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic        cc_clr = 1'b0, err_clr = 1'b0, cc_ie = 1'b0, be_ie = 1'b0;
    logic        hv_en, arr_pgm, arr_ers, cc_flag, be_flag, acc_err, cc_irq, be_irq;
    logic [15:0] arr_addr, arr_data;

    int n_run = 0;
    int n_fail = 0;
    int wd = 0;

    fcq_top i_fcq_top (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cc_clr(cc_clr),
        .err_clr(err_clr), .cc_ie(cc_ie), .be_ie(be_ie), .hv_en(hv_en),
        .arr_pgm(arr_pgm), .arr_ers(arr_ers), .arr_addr(arr_addr),
        .arr_data(arr_data), .cc_flag(cc_flag), .be_flag(be_flag),
        .acc_err(acc_err), .cc_irq(cc_irq), .be_irq(be_irq)
    );

    always #10 clk = ~clk;

    // Pair table: op1, addr1, op2, addr2, data2, last strobe cycle, hv ramps.
    localparam logic [63:0] VEC [7] = '{
        {2'b01, 16'h0100, 2'b01, 16'h0120, 16'h1111, 8'd20, 4'd1},
        {2'b01, 16'h0100, 2'b01, 16'h0140, 16'h2222, 8'd28, 4'd2},
        {2'b01, 16'h0200, 2'b10, 16'h0210, 16'h3333, 8'd32, 4'd2},
        {2'b10, 16'h0300, 2'b01, 16'h0300, 16'h4444, 8'd32, 4'd2},
        {2'b10, 16'h0300, 2'b10, 16'h0310, 16'h5555, 8'd36, 4'd2},
        {2'b01, 16'h003F, 2'b01, 16'h0040, 16'h6666, 8'd28, 4'd2},
        {2'b01, 16'h0040, 2'b01, 16'h007F, 16'h7777, 8'd20, 4'd1}
    };

    logic [1:0]  sq_op   [4];
    logic [15:0] sq_addr [4];
    logic [15:0] sq_data [4];
    int          sq_n;

    bit          hv_log  [LOGN];
    bit          act_log [LOGN];
    bit          cc_log  [LOGN];
    bit          be_log  [LOGN];
    bit          err_log [LOGN];
    int          k_last, hv_rises, op_rises;
    logic [15:0] first_addr, last_addr, last_data;
    bit          last_pgm;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", wd);
            summary();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic drive(input int i);
        cmd_wr   = 1'b1;
        cmd_op   = sq_op[i];
        cmd_addr = sq_addr[i];
        cmd_data = sq_data[i];
    endtask

    // Issue sq_n commands on consecutive edges; log outputs k edges after the first write.
    task automatic run_seq();
        bit hv_prev = 1'b0, act_prev = 1'b0, seen = 1'b0;
        k_last = -1; hv_rises = 0; op_rises = 0;
        first_addr = '0; last_addr = '0; last_data = '0; last_pgm = 1'b0;
        @(negedge clk);
        drive(0);
        for (int k = 0; k < LOGN; k++) begin
            @(negedge clk);
            if (k + 1 < sq_n) drive(k + 1);
            else cmd_wr = 1'b0;
            hv_log[k]  = hv_en;
            act_log[k] = arr_pgm || arr_ers;
            cc_log[k]  = cc_flag;
            be_log[k]  = be_flag;
            err_log[k] = acc_err;
            if (hv_en && !hv_prev) hv_rises++;
            if (act_log[k] && !act_prev) op_rises++;
            if (act_log[k]) begin
                if (!seen) first_addr = arr_addr;
                seen = 1'b1;
                k_last = k;
                last_addr = arr_addr;
                last_data = arr_data;
                last_pgm = arr_pgm;
            end
            hv_prev = hv_en;
            act_prev = act_log[k];
        end
    endtask

    task automatic pulse_cc_clr();
        @(negedge clk); cc_clr = 1'b1;
        @(negedge clk); cc_clr = 1'b0;
    endtask

    task automatic pulse_err_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check("R1 hv_en", hv_en, 0);
        check("R1 strobes", arr_pgm | arr_ers, 0);
        check("R1 cc_flag", cc_flag, 0);
        check("R1 be_flag", be_flag, 1);
        check("R1 acc_err", acc_err, 0);
        check("R1 irqs", cc_irq | be_irq, 0);
        be_ie = 1'b1;
        @(negedge clk);
        check("R9 be_irq with empty queue", be_irq, 1);

        // Table: R4 same-row chaining, R5 voltage drop, R2 ordering.
        for (int i = 0; i < 7; i++) begin
            logic [63:0] v;
            v = VEC[i];
            sq_n = 2;
            sq_op[0] = v[63:62]; sq_addr[0] = v[61:46]; sq_data[0] = 16'hA5A5;
            sq_op[1] = v[45:44]; sq_addr[1] = v[43:28]; sq_data[1] = v[27:12];
            run_seq();
            check("R4/R5 last strobe cycle", k_last, int'(v[11:4]));
            check("R4/R5 high-voltage ramps", hv_rises, int'(v[3:0]));
            check("R2 first address", first_addr, v[61:46]);
            check("R2 last address", last_addr, v[43:28]);
            check("R2 last strobe kind", last_pgm, (v[45:44] == 2'b01) ? 1 : 0);
            if (v[45:44] == 2'b01) check("R2 last data", last_data, v[27:12]);
        end

        // R3/R6/R7: single erase timing and flags.
        pulse_cc_clr();
        check("R6 cc_flag cleared", cc_flag, 0);
        cc_ie = 1'b1;
        sq_n = 1; sq_op[0] = 2'b10; sq_addr[0] = 16'h0500; sq_data[0] = 16'h0;
        run_seq();
        check("R3 hv off before ramp", hv_log[0], 0);
        check("R3 hv on cycle after pop", hv_log[1], 1);
        check("R3 erase strobe start", act_log[5], 1);
        check("R3 no strobe during ramp", act_log[4], 0);
        check("R3 erase last strobe", k_last, 16);
        check("R5 hv dropped after op", hv_log[17], 0);
        check("R7 be_flag with one pending", be_log[0], 0);
        check("R7 be_flag after pop", be_log[1], 1);
        check("R6 cc_flag before end", cc_log[16], 0);
        check("R6 cc_flag after end", cc_log[17], 1);
        check("R9 cc_irq", cc_irq, 1);
        cc_ie = 1'b0;
        @(negedge clk);
        check("R9 cc_irq gated", cc_irq, 0);
        pulse_cc_clr();
        check("R6 cc_clr clears", cc_flag, 0);

        // R8: fourth write into a full queue is refused.
        sq_n = 4;
        for (int i = 0; i < 4; i++) begin
            sq_op[i] = 2'b01; sq_addr[i] = 16'(i * 16'h0400); sq_data[i] = 16'(i + 1);
        end
        run_seq();
        check("R8 acc_err before overflow", err_log[2], 0);
        check("R8 acc_err on overflow", err_log[3], 1);
        check("R8 only three operations", op_rises, 3);
        check("R8 refused command not executed", last_addr, 16'h0800);
        check("R8 acc_err sticky", acc_err, 1);
        pulse_err_clr();
        check("R8 err_clr clears", acc_err, 0);

        // R8: illegal opcodes refused, no voltage, queue stays empty.
        for (int j = 0; j < 2; j++) begin
            sq_n = 1; sq_op[0] = (j == 0) ? 2'b11 : 2'b00; sq_addr[0] = 16'h0600;
            run_seq();
            check("R8 bad opcode sets acc_err", err_log[0], 1);
            check("R8 bad opcode no voltage", hv_rises, 0);
            check("R8 bad opcode queue empty", be_log[0], 1);
            pulse_err_clr();
        end

        summary();
    end

endmodule